// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write the registers of an Ethernet PHY over the two-wire serial management bus. The management clock (MDC) and the data line (MDIO) are produced here. The host works through a small register file: an address register that holds the PHY and register numbers, a write-data register, a command register, a read-data register and a status register with a busy flag. MDIO is presented as three pad signals: output value, output enable and input.

Writing the write-data register starts a write frame as a side effect. Writing the command register with its read bit set starts a read frame. In both cases the host polls the busy flag until it drops. For a read, the returned value is then valid in the read-data register. MDC is the system clock divided by a parameter. It stays low whenever no frame is in flight.

Each frame carries the following fields in order:

- 32 preamble ones
- start code 01
- a two-bit opcode
- a 5-bit PHY address
- a 5-bit register address
- two turnaround bits
- 16 data bits

After the data bits comes one idle bit with MDIO released. Every field is sent most significant bit first.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status register (offset 4, bit 0 = busy) reads 0, the read-data register (offset 3) reads 0, mdio_oe is 0 and mdc is 0.
- R2: A host write to offset 1 (write data) while not busy sends a frame whose 64 bits are, in MDC order: 32 ones, 01, opcode 01, the PHY address, the register address, turnaround 1 then 0, and the 16 data bits MSB first. mdio_oe is 1 for all 64 bits.
- R3: A host write to offset 2 with bit 0 = 1 while not busy sends a read frame with opcode 10. mdio_oe is 1 for the first 46 bits and 0 for both turnaround bits and all 16 data bits.
- R4: During a read, the block samples mdio_i on the rising MDC edge of each data bit, MSB first. The value appears at offset 3 when busy clears and does not change while busy is held.
- R5: Busy rises on the clock edge that accepts a launching write. It stays 1 for exactly 130 × MDC_HALF system clock cycles, which is 65 MDC periods.
- R6: After the data bits the frame ends with one idle bit during which mdio_oe is 0. mdio_oe is 0 whenever busy is 0.
- R7: Each MDC phase lasts MDC_HALF system clocks. mdio_o and mdio_oe change only on the edge where MDC falls or where the frame starts, so the PHY always samples stable data on the rising edge.
- R8: While busy is 1, writes to offsets 0, 1 and 2 are ignored: no further frame starts and the address and write-data registers keep their values.
- R9: A write to offset 2 with bit 0 = 0 starts nothing.
- R10: Offset 0 holds the PHY address in bits 9:5 and the register address in bits 4:0, and reads back what was written. Offset 1 reads back the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO pad input value |

## Verification
The hardest situation to reach is a host command that lands in the middle of a frame already in flight. This command has to be dropped without touching the stored address, the write data, the frame on the wire or the read result. The bench starts a read and then, while busy is still set, writes new values to the address, write-data and command registers. A PHY model paced by the MDC port returns known data. A scoreboard then confirms that exactly one frame appeared, that it carried the original fields, and that the registers read back unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDLE_IDX   = 64;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int IDX_W      = 7;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mgmt_op_e;

    typedef enum logic [2:0] {
        HR_ADDR  = 3'd0,
        HR_WDATA = 3'd1,
        HR_CMD   = 3'd2,
        HR_RDATA = 3'd3,
        HR_STAT  = 3'd4
    } host_reg_e;

    typedef struct packed {
        logic              valid;
        mgmt_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] data;
    } launch_t;

    // Bit k on the wire is element [FRAME_BITS-1-k]
    function automatic logic [FRAME_BITS-1:0] build_frame(input launch_t l);
        return {32'hFFFF_FFFF, 2'b01, l.op, l.phy, l.regn, 2'b10, l.data};
    endfunction

    function automatic logic master_drives(input mgmt_op_e op, input logic [IDX_W-1:0] idx);
        if (idx >= IDX_W'(IDLE_IDX)) return 1'b0;
        if (op == OPC_WRITE)         return 1'b1;
        return idx < IDX_W'(TA_IDX);
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MDC_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == LAST);
    assign rise_evt = wrap && !mdc_q;
    assign fall_evt = wrap && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output launch_t           launch
);
    logic [2*ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                accept;

    assign accept = reg_we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            if (reg_addr == HR_ADDR)  addr_q  <= reg_wdata[2*ADDR_W-1:0];
            if (reg_addr == HR_WDATA) wdata_q <= reg_wdata;
        end
    end

    always_comb begin
        launch       = '0;
        launch.phy   = addr_q[2*ADDR_W-1:ADDR_W];
        launch.regn  = addr_q[ADDR_W-1:0];
        launch.op    = OPC_WRITE;
        if (accept && reg_addr == HR_WDATA) begin
            launch.valid = 1'b1;
            launch.data  = reg_wdata;
        end else if (accept && reg_addr == HR_CMD && reg_wdata[0]) begin
            launch.valid = 1'b1;
            launch.op    = OPC_READ;
        end
    end

    always_comb begin
        case (reg_addr)
            HR_ADDR:  reg_rdata = {{(DATA_W-2*ADDR_W){1'b0}}, addr_q};
            HR_WDATA: reg_rdata = wdata_q;
            HR_RDATA: reg_rdata = rd_data;
            HR_STAT:  reg_rdata = {{(DATA_W-1){1'b0}}, busy};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  launch_t           launch,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    logic [FRAME_BITS-1:0] frame_q;
    logic [IDX_W-1:0]      idx_q;
    mgmt_op_e              op_q;
    logic                  busy_q;
    logic [DATA_W-1:0]     shift_q;
    logic [DATA_W-1:0]     rd_q;
    logic                  in_data;

    assign in_data = (idx_q >= IDX_W'(DATA_IDX)) && (idx_q < IDX_W'(IDLE_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            idx_q   <= '0;
            op_q    <= OPC_WRITE;
            busy_q  <= 1'b0;
            shift_q <= '0;
            rd_q    <= '0;
        end else if (!busy_q) begin
            if (launch.valid) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                op_q    <= launch.op;
                frame_q <= build_frame(launch);
            end
        end else begin
            if (rise_evt && op_q == OPC_READ && in_data)
                shift_q <= {shift_q[DATA_W-2:0], mdio_i};
            if (fall_evt) begin
                if (idx_q == IDX_W'(IDLE_IDX)) begin
                    busy_q <= 1'b0;
                    if (op_q == OPC_READ) rd_q <= shift_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign mdio_oe = busy_q && master_drives(op_q, idx_q);
    assign mdio_o  = mdio_oe && frame_q[~idx_q[5:0]];
    assign rd_data = rd_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    launch_t           launch;
    logic              busy;
    logic              rise_evt;
    logic              fall_evt;
    logic [DATA_W-1:0] rd_data;

    mdio_host_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .rd_data(rd_data), .launch(launch)
    );

    mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
        .clk(clk), .rst(rst), .run(busy), .mdc(mdc),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    mdio_frame_engine u_engine (
        .clk(clk), .rst(rst), .launch(launch), .rise_evt(rise_evt),
        .fall_evt(fall_evt), .mdio_i(mdio_i), .busy(busy),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        launch_valid,
    input logic [15:0] rd_data
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe); // R6
    AST_MDC_PARKED: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc); // R7
    AST_OE_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst) !$stable(mdio_oe) |-> ($fell(mdc) || $rose(busy))); // R7
    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(reg_we)); // R5
    AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !launch_valid); // R8
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(rd_data)); // R4
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .busy(busy), .mdc(mdc),
    .mdio_oe(mdio_oe), .launch_valid(launch.valid), .rd_data(rd_data)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_mgmt_master #(.MDC_HALF(HALF)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [64:0] eo;
        logic [64:0] eoe;
        string       tag;
    } exp_t;
    exp_t expq[$];

    logic        phy_rd = 1'b0;
    logic [15:0] phy_data = '0;
    int          bitn = 0;
    int          frames_seen = 0;
    logic [64:0] cap_o, cap_oe;
    realtime     t_first;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: collects one frame of 65 MDC rising edges, compares with scoreboard
    always @(posedge mdc) begin
        if (bitn == 0) t_first = $realtime;
        if (bitn == 1)
            check(($realtime - t_first) == 2.0 * HALF * 8.0, "R7", "mdc period",
                  80'(int'($realtime - t_first)), 80'(2 * HALF * 8));
        cap_o[bitn]  = mdio_o;
        cap_oe[bitn] = mdio_oe;
        bitn++;
        if (bitn == 65) begin
            exp_t e;
            bitn = 0;
            frames_seen++;
            if (expq.size() == 0) begin
                check(1'b0, "R8", "unexpected frame", 80'(cap_o), 80'(0));
            end else begin
                e = expq.pop_front();
                check(cap_oe == e.eoe, e.tag, "mdio_oe pattern", 80'(cap_oe), 80'(e.eoe));
                check((cap_o & e.eoe) == (e.eo & e.eoe), e.tag, "driven bits",
                      80'(cap_o & e.eoe), 80'(e.eo & e.eoe));
                check(cap_oe[64] == 1'b0, "R6", "idle bit released", 80'(cap_oe[64]), 80'(0));
            end
        end
    end

    // PHY model: drives read data after MDC falls
    always @(negedge mdc) begin
        if (phy_rd && bitn >= 48 && bitn < 64) mdio_i = phy_data[63 - bitn];
        else mdio_i = 1'b1;
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver side of the scoreboard: expected wire image from requirements R2/R3
    task automatic push_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] data, input string tag);
        exp_t e;
        logic [63:0] f;
        f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, data};
        for (int k = 0; k < 64; k++) begin
            e.eo[k]  = f[63 - k];
            e.eoe[k] = rd ? (k < 46) : 1'b1;
        end
        e.eo[64]  = 1'b0;
        e.eoe[64] = 1'b0;
        e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wait_idle(output int cyc);
        logic [15:0] s;
        cyc = 0;
        forever begin
            reg_read(3'd4, s);
            if (!s[0]) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] data);
        int c;
        reg_write(3'd0, {6'd0, phy, rg});
        push_frame(1'b0, phy, rg, data, "R2");
        phy_rd = 1'b0;
        reg_write(3'd1, data);
        wait_idle(c);
        check(c == 130 * HALF, "R5", "busy length on write", 80'(c), 80'(130 * HALF));
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pdata);
        int c;
        logic [15:0] d;
        reg_write(3'd0, {6'd0, phy, rg});
        push_frame(1'b1, phy, rg, 16'h0, "R3");
        phy_rd = 1'b1;
        phy_data = pdata;
        reg_write(3'd2, 16'h0001);
        wait_idle(c);
        check(c == 130 * HALF, "R5", "busy length on read", 80'(c), 80'(130 * HALF));
        reg_read(3'd3, d);
        check(d == pdata, "R4", "read data", 80'(d), 80'(pdata));
        phy_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(3'd4, d);
        check(d == 16'h0, "R1", "status after reset", 80'(d), 80'(0));
        reg_read(3'd3, d);
        check(d == 16'h0, "R1", "read data after reset", 80'(d), 80'(0));
        check(!mdio_oe && !mdc, "R1", "pads after reset", 80'({mdio_oe, mdc}), 80'(0));

        // R10 address register readback
        reg_write(3'd0, {6'd0, 5'd5, 5'd3});
        reg_read(3'd0, d);
        check(d == {6'd0, 5'd5, 5'd3}, "R10", "address readback", 80'(d), 80'({5'd5, 5'd3}));

        do_write(5'd5, 5'd3, 16'hA5C3);
        reg_read(3'd1, d);
        check(d == 16'hA5C3, "R10", "write data readback", 80'(d), 80'(16'hA5C3));
        do_read(5'd31, 5'd0, 16'h8001);
        do_write(5'd0, 5'd31, 16'h0000);
        do_write(5'd17, 5'd10, 16'hFFFF);

        // R8: commands during a read in flight are dropped
        reg_write(3'd0, {6'd0, 5'd9, 5'd4});
        push_frame(1'b1, 5'd9, 5'd4, 16'h0, "R8");
        phy_rd = 1'b1;
        phy_data = 16'h1234;
        reg_write(3'd2, 16'h0001);
        repeat (20) @(negedge clk);
        reg_write(3'd1, 16'hBEEF);
        reg_write(3'd0, 16'h03FF);
        repeat (100) @(negedge clk);
        reg_write(3'd2, 16'h0001);
        wait_idle(c);
        reg_read(3'd3, d);
        check(d == 16'h1234, "R8", "read result untouched", 80'(d), 80'(16'h1234));
        reg_read(3'd0, d);
        check(d == {6'd0, 5'd9, 5'd4}, "R8", "address kept", 80'(d), 80'({5'd9, 5'd4}));
        reg_read(3'd1, d);
        check(d == 16'hFFFF, "R8", "write data kept", 80'(d), 80'(16'hFFFF));
        phy_rd = 1'b0;
        repeat (40) @(negedge clk);
        reg_read(3'd4, d);
        check(d == 16'h0, "R8", "no frame restarted", 80'(d), 80'(0));

        // R9: command without read bit
        reg_write(3'd2, 16'hFFFE);
        reg_read(3'd4, d);
        check(d == 16'h0 && !mdc, "R9", "no launch on bit0=0", 80'({d[0], mdc}), 80'(0));
        repeat (40) @(negedge clk);

        do_read(5'd10, 5'd16, 16'h3C5A);
        repeat (20) @(negedge clk);

        check(expq.size() == 0, "R2", "scoreboard drained", 80'(expq.size()), 80'(0));
        check(frames_seen == 6, "R8", "frame count", 80'(frames_seen), 80'(6));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule